// File: doc/BRIEF.md
# Memory Access Permission Checker

This block decides whether a single memory access may proceed. It takes the access start address, a byte count, the requested read, write and execute bits, and whether the requester runs in machine mode or a lower mode. It also takes the already decoded inclusive bounds and configuration byte of every protection entry, a count of active rules, and two policy bits. One policy bit enables a lockdown mode in which machine mode is itself restricted. The other enables a whitelist mode in which any unmatched access is refused.

Entries are examined in ascending index order, and the first entry the access touches decides the outcome. An access that only partly falls inside that entry is refused outright. An access that falls fully inside it is judged against the permissions of that entry. When no entry is touched, or no rules are active, a default policy applies. The verdict is registered, so a request presented with `req_valid` in one cycle is answered on the following clock edge.

Configuration byte layout: bit 0 is R, bit 1 is W, bit 2 is X, bits [4:3] hold the match mode (0 means the entry is off), bit 7 is the lock bit, and bits [6:5] are ignored. Permission vectors (`req_perm`, `rsp_allow`) use bit 0 for R, bit 1 for W and bit 2 for X. Entry i occupies bits [i*ADDR_W +: ADDR_W] of the bound vectors and bits [i*8 +: 8] of the configuration vector.

Top module: `access_perm_checker`

## Requirements
- R1: The access spans `req_addr` through `req_addr + n - 1`, modulo 2^ADDR_W. Here n is `req_size`, except that a size of 0 means 4 bytes when `wide_word` is 0 and 8 bytes when it is 1.
- R2: If the lowest-indexed active entry that contains at least one endpoint contains exactly one of them, the verdict is deny with an empty allowed set, whatever higher-indexed entries hold.
- R3: An entry whose mode bits [4:3] are 0 is skipped. The lowest-indexed active entry that contains both endpoints decides, and the access is granted only if every requested bit is in that entry's allowed set.
- R4: With lockdown clear, a matching entry gives machine mode RWX when its lock bit is 0. Lower modes, and machine mode on a locked entry, get the entry's own R/W/X bits.
- R5: With lockdown set, a matching entry gives machine mode permissions from the 4-bit index {L,R,W,X}: 0,1,4,5,6,7,8 give none; 2,3,14 give RW; 9,10 give X; 11,13 give RX; 12,15 give R.
- R6: With lockdown set, a matching entry gives lower modes permissions from the same index: 0,8,9,12,13,14 give none; 1,10,11 give X; 2,4,15 give R; 3,6 give RW; 5 gives RX; 7 gives RWX.
- R7: When the default applies and whitelist mode is set, the access is denied with an empty allowed set.
- R8: When the default applies with whitelist clear and lockdown set, a machine-mode request without X is granted with allowed set RW. Every other request is denied with an empty set.
- R9: When the default applies with both policy bits clear, machine mode is granted RWX and lower modes are denied with an empty set.
- R10: When `active_rules` is 0, the default applies regardless of the entry bounds and configurations.
- R11: `rsp_valid` equals `req_valid` delayed by one clock, and `rsp_grant`/`rsp_allow` carry the verdict for that request. After reset all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | First byte address of the access |
| req_size | input | SIZE_W | Byte count, 0 meaning one register word |
| req_perm | input | 3 | Requested R/W/X bits |
| req_mmode | input | 1 | 1 for machine mode, 0 for a lower mode |
| wide_word | input | 1 | Register word is 8 bytes (1) or 4 bytes (0) |
| ent_lo | input | NUM_ENT*ADDR_W | Inclusive lower bound of every entry |
| ent_hi | input | NUM_ENT*ADDR_W | Inclusive upper bound of every entry |
| ent_cfg | input | NUM_ENT*8 | Configuration byte of every entry |
| active_rules | input | CNT_W | Number of active rules |
| pol_lockdown | input | 1 | Machine-mode lockdown policy |
| pol_whitelist | input | 1 | Deny-unmatched policy |
| rsp_valid | output | 1 | Verdict present |
| rsp_grant | output | 1 | Access granted |
| rsp_allow | output | 3 | Allowed R/W/X set |

## Verification
Any fault in the internal state shows up on the verdict one clock after the request. A wrong endpoint sum makes accesses near an entry edge flip between partial denial and full match. A broken priority pick lets a higher-indexed entry override a lower one, which shows as a different `rsp_allow`. A corrupted lockdown table row produces a wrong allowed set for exactly that {L,R,W,X} index. For that reason all 16 indices are swept in both privilege modes, and random bounds and requests cover the mixed cases.

// File: rtl/apc_pkg.sv
package apc_pkg;

    localparam int CFG_W  = 8;
    localparam int PERM_W = 3;

    typedef logic [PERM_W-1:0] perm_t;

    localparam perm_t P_NONE = 3'b000;
    localparam perm_t P_R    = 3'b001;
    localparam perm_t P_X    = 3'b100;
    localparam perm_t P_RW   = 3'b011;
    localparam perm_t P_RX   = 3'b101;
    localparam perm_t P_RWX  = 3'b111;

    typedef struct packed {
        logic       lock;
        logic [1:0] spare;
        logic [1:0] amode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_t;

    typedef struct packed {
        logic  grant;
        perm_t allow;
    } verdict_t;

    typedef enum logic [1:0] {
        HIT_NONE    = 2'd0,
        HIT_PARTIAL = 2'd1,
        HIT_FULL    = 2'd2
    } hit_e;

    function automatic logic cfg_active(cfg_t c);
        return c.amode != 2'b00;
    endfunction

    function automatic perm_t cfg_perm(cfg_t c);
        return {c.x, c.w, c.r};
    endfunction

    function automatic logic [3:0] lockdown_index(cfg_t c);
        return {c.lock, c.r, c.w, c.x};
    endfunction

    function automatic perm_t lockdown_machine(logic [3:0] idx);
        case (idx)
            4'd2, 4'd3, 4'd14: return P_RW;
            4'd9, 4'd10:       return P_X;
            4'd11, 4'd13:      return P_RX;
            4'd12, 4'd15:      return P_R;
            default:           return P_NONE;
        endcase
    endfunction

    function automatic perm_t lockdown_lower(logic [3:0] idx);
        case (idx)
            4'd1, 4'd10, 4'd11: return P_X;
            4'd2, 4'd4, 4'd15:  return P_R;
            4'd3, 4'd6:         return P_RW;
            4'd5:               return P_RX;
            4'd7:               return P_RWX;
            default:            return P_NONE;
        endcase
    endfunction

    function automatic perm_t legacy_perm(cfg_t c, logic mmode);
        if (mmode && !c.lock) return P_RWX;
        return cfg_perm(c);
    endfunction

    function automatic perm_t entry_perm(cfg_t c, logic mmode, logic lockdown);
        if (!lockdown) return legacy_perm(c, mmode);
        if (mmode)     return lockdown_machine(lockdown_index(c));
        return lockdown_lower(lockdown_index(c));
    endfunction

    function automatic logic covers(perm_t want, perm_t have);
        return (want & have) == want;
    endfunction

    function automatic verdict_t default_verdict(logic whitelist, logic lockdown,
                                                 logic mmode, perm_t want);
        verdict_t v;
        v = '{grant: 1'b0, allow: P_NONE};
        if (whitelist) begin
            v = '{grant: 1'b0, allow: P_NONE};
        end else if (lockdown) begin
            if (mmode && !want[2]) v = '{grant: 1'b1, allow: P_RW};
        end else if (mmode) begin
            v = '{grant: 1'b1, allow: P_RWX};
        end
        return v;
    endfunction

endpackage

// File: rtl/apc_span.sv
module apc_span #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              wide_word,
    output logic [ADDR_W-1:0] last_addr
);
    localparam int EXT_W = (SIZE_W > 4) ? SIZE_W : 4;

    logic [EXT_W-1:0] eff_bytes;

    always_comb begin
        if (size == '0) eff_bytes = wide_word ? EXT_W'(8) : EXT_W'(4);
        else            eff_bytes = EXT_W'(size);
        last_addr = first_addr + ADDR_W'(eff_bytes) - ADDR_W'(1);
    end
endmodule

// File: rtl/apc_entry_match.sv
module apc_entry_match
    import apc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    input  cfg_t              cfg,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              active,
    output logic              has_first,
    output logic              has_last
);
    always_comb begin
        active    = cfg_active(cfg);
        has_first = (first_addr >= lo) && (first_addr <= hi);
        has_last  = (last_addr  >= lo) && (last_addr  <= hi);
    end
endmodule

// File: rtl/apc_prio_pick.sv
module apc_prio_pick
    import apc_pkg::*;
#(
    parameter int NUM_ENT = 8
) (
    input  logic [NUM_ENT-1:0] active,
    input  logic [NUM_ENT-1:0] has_first,
    input  logic [NUM_ENT-1:0] has_last,
    output logic [NUM_ENT-1:0] sel_oh,
    output hit_e               kind
);
    logic [NUM_ENT-1:0] touched;
    logic [NUM_ENT-1:0] split;

    always_comb begin
        touched = active & (has_first | has_last);
        split   = has_first ^ has_last;
        sel_oh  = touched & (~touched + NUM_ENT'(1));
        if (sel_oh == '0)            kind = HIT_NONE;
        else if ((sel_oh & split) != '0) kind = HIT_PARTIAL;
        else                         kind = HIT_FULL;
    end
endmodule

// File: rtl/access_perm_checker.sv
module access_perm_checker
    import apc_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int ADDR_W  = 32,
    parameter int SIZE_W  = 4,
    parameter int CNT_W   = $clog2(NUM_ENT + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [SIZE_W-1:0]          req_size,
    input  logic [2:0]                 req_perm,
    input  logic                       req_mmode,
    input  logic                       wide_word,
    input  logic [NUM_ENT*ADDR_W-1:0]  ent_lo,
    input  logic [NUM_ENT*ADDR_W-1:0]  ent_hi,
    input  logic [NUM_ENT*CFG_W-1:0]   ent_cfg,
    input  logic [CNT_W-1:0]           active_rules,
    input  logic                       pol_lockdown,
    input  logic                       pol_whitelist,
    output logic                       rsp_valid,
    output logic                       rsp_grant,
    output logic [2:0]                 rsp_allow
);
    logic [ADDR_W-1:0]  last_addr;
    logic [NUM_ENT-1:0] ent_active;
    logic [NUM_ENT-1:0] ent_first;
    logic [NUM_ENT-1:0] ent_last;
    logic [NUM_ENT-1:0] sel_oh;
    hit_e               hit_kind;
    cfg_t               sel_cfg;
    verdict_t           next_v;
    verdict_t           rsp_v;

    apc_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_span (
        .first_addr (req_addr),
        .size       (req_size),
        .wide_word  (wide_word),
        .last_addr  (last_addr)
    );

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        apc_entry_match #(.ADDR_W(ADDR_W)) u_match (
            .lo         (ent_lo[g*ADDR_W +: ADDR_W]),
            .hi         (ent_hi[g*ADDR_W +: ADDR_W]),
            .cfg        (cfg_t'(ent_cfg[g*CFG_W +: CFG_W])),
            .first_addr (req_addr),
            .last_addr  (last_addr),
            .active     (ent_active[g]),
            .has_first  (ent_first[g]),
            .has_last   (ent_last[g])
        );
    end

    apc_prio_pick #(.NUM_ENT(NUM_ENT)) u_pick (
        .active    (ent_active),
        .has_first (ent_first),
        .has_last  (ent_last),
        .sel_oh    (sel_oh),
        .kind      (hit_kind)
    );

    always_comb begin
        sel_cfg = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (sel_oh[i]) sel_cfg = sel_cfg | cfg_t'(ent_cfg[i*CFG_W +: CFG_W]);
        end
    end

    always_comb begin
        perm_t allow;
        allow  = entry_perm(sel_cfg, req_mmode, pol_lockdown);
        next_v = default_verdict(pol_whitelist, pol_lockdown, req_mmode, req_perm);
        if (active_rules != '0) begin
            if (hit_kind == HIT_PARTIAL) begin
                next_v = '{grant: 1'b0, allow: P_NONE};
            end else if (hit_kind == HIT_FULL) begin
                next_v = '{grant: covers(req_perm, allow), allow: allow};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_v     <= '{grant: 1'b0, allow: P_NONE};
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_v <= next_v;
        end
    end

    assign rsp_grant = rsp_v.grant;
    assign rsp_allow = rsp_v.allow;
endmodule

// File: rtl/access_perm_checker_chk.sv
module access_perm_checker_chk
    import apc_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int CNT_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [2:0]         req_perm,
    input logic               req_mmode,
    input logic               pol_lockdown,
    input logic               pol_whitelist,
    input logic [CNT_W-1:0]   active_rules,
    input logic [NUM_ENT-1:0] sel_oh,
    input hit_e               hit_kind,
    input logic               rsp_valid,
    input logic               rsp_grant,
    input logic [2:0]         rsp_allow
);
    logic use_default;
    assign use_default = (active_rules == '0) || (hit_kind == HIT_NONE);

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R11
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R3
    single_pick_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_oh));

    // R3
    grant_covers_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_grant || (($past(req_perm) & rsp_allow) == $past(req_perm))));

    // R2
    partial_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && active_rules != '0 && hit_kind == HIT_PARTIAL)
        |=> (!rsp_grant && rsp_allow == 3'b000));

    // R7
    whitelist_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && use_default && pol_whitelist)
        |=> (!rsp_grant && rsp_allow == 3'b000));

    // R8
    lockdown_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && use_default && pol_lockdown && (req_perm[2] || !req_mmode))
        |=> !rsp_grant);
endmodule

bind access_perm_checker access_perm_checker_chk #(
    .NUM_ENT (NUM_ENT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_perm      (req_perm),
    .req_mmode     (req_mmode),
    .pol_lockdown  (pol_lockdown),
    .pol_whitelist (pol_whitelist),
    .active_rules  (active_rules),
    .sel_oh        (sel_oh),
    .hit_kind      (hit_kind),
    .rsp_valid     (rsp_valid),
    .rsp_grant     (rsp_grant),
    .rsp_allow     (rsp_allow)
);

// File: tb/access_perm_checker_test.sv
`timescale 1ns/1ps
module access_perm_checker_test;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int SW = 4;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [2:0]    req_perm = '0;
    logic          req_mmode = 1'b0;
    logic          wide_word = 1'b0;
    logic          pol_lockdown = 1'b0;
    logic          pol_whitelist = 1'b0;
    logic [CW-1:0] active_rules = '0;
    logic [AW-1:0] lo [N];
    logic [AW-1:0] hi [N];
    logic [7:0]    cfg [N];
    logic [N*AW-1:0] lo_flat, hi_flat;
    logic [N*8-1:0]  cfg_flat;
    logic          rsp_valid, rsp_grant;
    logic [2:0]    rsp_allow;

    for (genvar g = 0; g < N; g++) begin : g_pack
        assign lo_flat[g*AW +: AW] = lo[g];
        assign hi_flat[g*AW +: AW] = hi[g];
        assign cfg_flat[g*8 +: 8]  = cfg[g];
    end

    access_perm_checker #(.NUM_ENT(N), .ADDR_W(AW), .SIZE_W(SW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_perm(req_perm), .req_mmode(req_mmode),
        .wide_word(wide_word), .ent_lo(lo_flat), .ent_hi(hi_flat), .ent_cfg(cfg_flat),
        .active_rules(active_rules), .pol_lockdown(pol_lockdown),
        .pol_whitelist(pol_whitelist), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant),
        .rsp_allow(rsp_allow)
    );

    int  tests = 0;
    int  fails = 0;
    bit  done  = 0;

    // R5 machine table, R6 lower table, index {L,R,W,X}
    function automatic logic [2:0] tbl_m(logic [3:0] k);
        if (k inside {4'd2, 4'd3, 4'd14}) return 3'b011;
        if (k inside {4'd9, 4'd10})       return 3'b100;
        if (k inside {4'd11, 4'd13})      return 3'b101;
        if (k inside {4'd12, 4'd15})      return 3'b001;
        return 3'b000;
    endfunction

    function automatic logic [2:0] tbl_u(logic [3:0] k);
        if (k == 4'd7)                    return 3'b111;
        if (k == 4'd5)                    return 3'b101;
        if (k inside {4'd3, 4'd6})        return 3'b011;
        if (k inside {4'd2, 4'd4, 4'd15}) return 3'b001;
        if (k inside {4'd1, 4'd10, 4'd11}) return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [3:0] ref_verdict();
        logic [AW-1:0] last;
        logic [2:0] al;
        logic s, e;
        last = req_addr + ((req_size == 0) ? (wide_word ? 32'd8 : 32'd4) : AW'(req_size)) - 32'd1;
        if (active_rules != 0) begin
            for (int i = 0; i < N; i++) begin
                if (cfg[i][4:3] != 2'b00) begin
                    s = (req_addr >= lo[i]) && (req_addr <= hi[i]);
                    e = (last >= lo[i]) && (last <= hi[i]);
                    if (s != e) return 4'b0000;
                    if (s && e) begin
                        if (!pol_lockdown)
                            al = (req_mmode && !cfg[i][7]) ? 3'b111 : cfg[i][2:0];
                        else if (req_mmode)
                            al = tbl_m({cfg[i][7], cfg[i][0], cfg[i][1], cfg[i][2]});
                        else
                            al = tbl_u({cfg[i][7], cfg[i][0], cfg[i][1], cfg[i][2]});
                        return {((req_perm & al) == req_perm), al};
                    end
                end
            end
        end
        if (pol_whitelist) return 4'b0000;
        if (pol_lockdown)  return (req_mmode && !req_perm[2]) ? 4'b1011 : 4'b0000;
        return req_mmode ? 4'b1111 : 4'b0000;
    endfunction

    task automatic expect_v(string tag, logic [3:0] exp);
        tests++;
        if (!(rsp_valid === 1'b1 && {rsp_grant, rsp_allow} === exp)) begin
            fails++;
            $display("FAIL %s: got valid=%0b grant=%0b allow=%03b, expected valid=1 grant=%0b allow=%03b",
                     tag, rsp_valid, rsp_grant, rsp_allow, exp[3], exp[2:0]);
        end
    endtask

    task automatic issue(string tag);
        logic [3:0] exp;
        exp = ref_verdict();
        req_valid = 1'b1;
        @(negedge clk);
        expect_v(tag, exp);
        req_valid = 1'b0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            lo[i] = '0; hi[i] = '0; cfg[i] = '0;
        end
        active_rules = CW'(N);
        pol_lockdown = 0; pol_whitelist = 0; wide_word = 0;
    endtask

    task automatic put(int i, int l, int h, logic [7:0] c);
        lo[i] = AW'(l); hi[i] = AW'(h); cfg[i] = c;
    endtask

    task automatic req(int a, int sz, logic [2:0] p, logic mm);
        req_addr = AW'(a); req_size = SW'(sz); req_perm = p; req_mmode = mm;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog R11: got no end of run, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_all();
        repeat (3) @(negedge clk);
        // R11 reset state
        tests++;
        if (!(rsp_valid === 0 && rsp_grant === 0 && rsp_allow === 3'b000)) begin
            fails++;
            $display("FAIL R11 reset: got %0b%0b%03b, expected 00000", rsp_valid, rsp_grant, rsp_allow);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1 word-sized access, 4 versus 8 bytes
        put(0, 100, 103, 8'h0F);
        req(100, 0, 3'b001, 0); wide_word = 0; issue("R1 size0 narrow");
        wide_word = 1; issue("R1 size0 wide partial");
        wide_word = 0;
        req(98, 3, 3'b001, 0); issue("R1 explicit size straddle");

        // R11 idle cycle after a request
        @(negedge clk);
        tests++;
        if (rsp_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 idle: got valid=%0b, expected 0", rsp_valid);
        end

        // R2 partial in lower entry wins over full in higher
        clear_all();
        put(0, 0, 50, 8'h0F); put(1, 40, 200, 8'h0F);
        req(45, 10, 3'b001, 1); issue("R2 partial priority");

        // R3 priority and OFF skip
        clear_all();
        put(0, 10, 20, 8'h09); put(1, 0, 100, 8'h0F);
        req(12, 4, 3'b010, 0); issue("R3 low entry decides");
        cfg[0] = 8'h07; issue("R3 off entry skipped");

        // R4 legacy lock semantics
        clear_all();
        put(0, 0, 255, 8'h09);
        req(16, 4, 3'b010, 1); issue("R4 machine unlocked");
        cfg[0] = 8'h89; issue("R4 machine locked");
        req(16, 4, 3'b001, 0); cfg[0] = 8'h09; issue("R4 lower mode");

        // R5 and R6 full sweep of the lockdown tables
        for (int k = 0; k < 16; k++) begin
            clear_all();
            pol_lockdown = 1;
            put(0, 0, 255, {k[3], 2'b00, 2'b01, k[0], k[1], k[2]});
            req(32, 4, 3'b000, 1); issue("R5 machine table");
            req(32, 4, 3'b000, 0); issue("R6 lower table");
        end

        // R7 whitelist default
        clear_all();
        pol_whitelist = 1; pol_lockdown = 1;
        req(5, 1, 3'b001, 1); issue("R7 whitelist deny");

        // R8 lockdown default
        clear_all();
        pol_lockdown = 1;
        req(5, 1, 3'b011, 1); issue("R8 machine rw");
        req(5, 1, 3'b100, 1); issue("R8 machine exec");
        req(5, 1, 3'b001, 0); issue("R8 lower");

        // R9 plain default
        clear_all();
        req(5, 1, 3'b100, 1); issue("R9 machine");
        req(5, 1, 3'b001, 0); issue("R9 lower");

        // R10 zero active rules bypasses entries
        clear_all();
        put(0, 0, 255, 8'h09);
        active_rules = 0;
        req(8, 4, 3'b001, 0); issue("R10 lower default");
        cfg[0] = 8'h89;
        req(8, 4, 3'b010, 1); issue("R10 machine default");

        // random mix, all requirements R2 to R10
        for (int n = 0; n < 800; n++) begin
            for (int i = 0; i < N; i++) begin
                int l;
                l = $urandom_range(0, 200);
                put(i, l, l + $urandom_range(0, 60), 8'($urandom));
            end
            active_rules  = ($urandom_range(0, 7) == 0) ? '0 : CW'($urandom_range(1, N));
            pol_lockdown  = 1'($urandom);
            pol_whitelist = ($urandom_range(0, 3) == 0);
            wide_word     = 1'($urandom);
            req($urandom_range(0, 280), $urandom_range(0, 15), 3'($urandom), 1'($urandom));
            issue("R3 random");
        end

        done = 1;
        summary();
        $finish;
    end
endmodule